// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Lookup

This block is the lookup path of a set-associative level-one data cache. A request carries a virtual address. The set is selected with address bits that lie inside the 4 KiB page offset, and those bits are the same before and after translation. While the tag row of that set is read, a small fully associative translation buffer maps the virtual page number to a physical frame number. The frame number is then compared with the physical tags of every way in the row. Because the stored tags are physical, two virtual pages that map to the same frame reach the same line and report the same way.

The response is registered and arrives one cycle after the request. It gives a hit flag, the hit way, the translated physical address, a translation-miss flag and a colour-mismatch flag. A refill port writes a frame tag into the victim way of a chosen set. The victim is picked by a round-robin pointer kept for each set, and the current victim is shown combinationally. A synchronous flush clears every line valid bit and every translation entry.

An optional colouring width of 1 or 2 bits lets the set index reach above bit 11. In that case the low page-number bits of the virtual and physical page must agree, and any request where they differ is flagged. The legal geometry is LINE_BITS + log2(SETS) <= 12 + COLOR_BITS, with SETS and WAYS powers of two and WAYS at least 2.

Top module: `vipt_lookup`

## Requirements
- R1: On a translation hit, rsp_paddr equals the translated frame number placed above the unchanged low 12 bits of req_vaddr. On a translation miss it is zero.
- R2: The lookup set is req_vaddr[LINE_BITS+log2(SETS)-1:LINE_BITS] and the refill set is fill_set. A refill or eviction in one set does not change lookups in any other set, whatever the byte offset within the line.
- R3: rsp_hit is 1 exactly when the translation hits, there is no colour mismatch, and a valid way in the selected set holds a tag equal to the full translated frame number. rsp_way then gives that way's number. When rsp_hit is 0, rsp_way is 0.
- R4: Two virtual addresses whose pages translate to the same frame and whose set and line bits are equal report a hit on the same way.
- R5: When no valid translation entry matches the virtual page number, rsp_tlb_miss is 1 and rsp_hit, rsp_color_err and rsp_paddr are 0.
- R6: Every request gets a response exactly one cycle later, with rsp_valid high for that one cycle. rsp_valid is 0 in a cycle that follows a cycle with no request. A request sees the contents as they were before a refill or flush in the same cycle.
- R7: fill_victim shows the round-robin pointer of the set on fill_set. After reset every set's pointer is way 0. Each accepted refill writes the tag into that way, marks it valid, and advances the pointer by one, wrapping from WAYS-1 to 0. A flush leaves the pointers unchanged.
- R8: A flush clears all line valid bits and all translation entries in the next cycle. A refill or translation write in the same cycle as a flush is dropped.
- R9: With COLOR_BITS > 0, a translation hit whose low COLOR_BITS page-number bits differ from those of the frame number gives rsp_color_err = 1 and rsp_hit = 0. rsp_paddr still carries the translation.
- R10: A translation write replaces the entry in the named slot and makes it valid. When several valid entries match, the lowest-numbered slot supplies the frame number.
- R11: After reset no line or translation entry is valid, rsp_valid is 0, and fill_victim is 0 for every set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush_all | input | 1 | Synchronous invalidate of all lines and translations |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | VA_W | Virtual byte address of the request |
| tlb_wr | input | 1 | Translation entry write |
| tlb_wr_slot | input | log2(TLB_ENTRIES) | Slot to write |
| tlb_wr_vpn | input | VA_W-12 | Virtual page number to store |
| tlb_wr_pfn | input | PA_W-12 | Physical frame number to store |
| fill_valid | input | 1 | Refill write strobe |
| fill_set | input | log2(SETS) | Set receiving the refill |
| fill_pfn | input | PA_W-12 | Physical frame tag written by the refill |
| fill_victim | output | log2(WAYS) | Way the next refill of fill_set will write |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Line hit |
| rsp_way | output | log2(WAYS) | Hit way |
| rsp_paddr | output | PA_W | Translated physical address |
| rsp_tlb_miss | output | 1 | No translation for the request |
| rsp_color_err | output | 1 | Colour bits of page and frame disagree |

## Verification
All lookup results are registered, so they are due on the first rising edge after the request. The bench raises a request at a falling edge and reads every response field at the next falling edge. One cycle after that, with no request, it expects rsp_valid low. fill_victim is combinational, so the bench samples it 1 ns after setting fill_set, before the edge that performs the refill. Expected values come from a bench-side model of tags, pointers and translations, which is updated only after each cycle's expectation is taken, so a same-cycle refill or flush is judged against the older contents.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

  // Outcome of one lookup before it is registered.
  typedef enum logic [2:0] {
    LK_IDLE,
    LK_HIT,
    LK_LINE_MISS,
    LK_TLB_MISS,
    LK_COLOR_ERR
  } lk_kind_e;

  // Order of tests sets the precedence of the flags.
  function automatic lk_kind_e classify(input logic req, input logic tlb_hit,
                                        input logic color_bad, input logic line_hit);
    if (!req)       return LK_IDLE;
    if (!tlb_hit)   return LK_TLB_MISS;
    if (color_bad)  return LK_COLOR_ERR;
    if (line_hit)   return LK_HIT;
    return LK_LINE_MISS;
  endfunction

endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ENTRIES = 8,
  localparam int SLOT_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [ENTRIES-1:0] hit_vec,
  output logic              any_valid
);

  logic [ENTRIES-1:0] v_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      v_q <= '0;
    else if (flush)  v_q <= '0;
    else if (wr_en)  v_q[wr_slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      vpn_q[wr_slot] <= wr_vpn;
      pfn_q[wr_slot] <= wr_pfn;
    end
  end

  // One comparator per entry, all active at once.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit_vec[e] = v_q[e] && (vpn_q[e] == lk_vpn);
  end

  // Lowest matching slot wins: scan downward, last write stands.
  always_comb begin
    lk_hit = 1'b0;
    lk_pfn = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (hit_vec[e]) begin
        lk_hit = 1'b1;
        lk_pfn = pfn_q[e];
      end
    end
  end

  assign any_valid = |v_q;

endmodule

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic [IDX_W-1:0]            rd_set,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tags,
  output logic [WAYS-1:0]             rd_valid,
  input  logic                        fill_en,
  input  logic [IDX_W-1:0]            fill_set,
  input  logic [TAG_W-1:0]            fill_tag,
  output logic [WAY_W-1:0]            victim,
  output logic                        any_valid
);

  logic [WAYS-1:0]  val_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAY_W-1:0] rr_q  [SETS];

  logic fill_go;
  assign fill_go = fill_en && !flush;
  assign victim  = rr_q[fill_set];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        val_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) val_q[s] <= '0;
    end else if (fill_en) begin
      val_q[fill_set][rr_q[fill_set]] <= 1'b1;
      rr_q[fill_set] <= rr_q[fill_set] + WAY_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) tag_q[fill_set][rr_q[fill_set]] <= fill_tag;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_tags[w] = tag_q[rd_set][w];
  end
  assign rd_valid = val_q[rd_set];

  always_comb begin
    logic [WAYS-1:0] acc;
    acc = '0;
    for (int s = 0; s < SETS; s++) acc = acc | val_q[s];
    any_valid = |acc;
  end

endmodule

// File: rtl/vipt_way_match.sv
module vipt_way_match #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [WAYS-1:0]            valid,
  input  logic [TAG_W-1:0]           key,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec[w] = valid[w] && (tags[w] == key);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup import vipt_pkg::*; #(
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int PAGE_BITS   = 12,
  parameter int LINE_BITS   = 6,
  parameter int SETS        = 64,
  parameter int WAYS        = 8,
  parameter int TLB_ENTRIES = 8,
  parameter int COLOR_BITS  = 0,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int VPN_W  = VA_W - PAGE_BITS,
  localparam int PFN_W  = PA_W - PAGE_BITS,
  localparam int SLOT_W = $clog2(TLB_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_all,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              tlb_wr,
  input  logic [SLOT_W-1:0] tlb_wr_slot,
  input  logic [VPN_W-1:0]  tlb_wr_vpn,
  input  logic [PFN_W-1:0]  tlb_wr_pfn,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_set,
  input  logic [PFN_W-1:0]  fill_pfn,
  output logic [WAY_W-1:0]  fill_victim,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_tlb_miss,
  output logic              rsp_color_err
);

  // Set index comes from bits that translation leaves untouched
  // (plus colour bits when enabled).
  function automatic logic [IDX_W-1:0] set_of(input logic [VA_W-1:0] va);
    return va[LINE_BITS +: IDX_W];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PFN_W-1:0] pfn,
                                              input logic [VA_W-1:0]  va);
    return {pfn, va[PAGE_BITS-1:0]};
  endfunction

  // Named internal events, observed by the bound checker.
  logic [VPN_W-1:0]           lk_vpn;
  logic [IDX_W-1:0]           lk_set;
  logic                       tlb_hit;
  logic [PFN_W-1:0]           tlb_pfn;
  logic [TLB_ENTRIES-1:0]     tlb_hit_vec;
  logic                       tlb_valid_any;
  logic [WAYS-1:0][PFN_W-1:0] row_tags;
  logic [WAYS-1:0]            row_valid;
  logic [WAYS-1:0]            way_hit_vec;
  logic                       line_hit;
  logic [WAY_W-1:0]           line_way;
  logic                       lines_valid_any;
  logic                       color_bad;
  lk_kind_e                   lk_kind;

  assign lk_vpn = req_vaddr[VA_W-1:PAGE_BITS];
  assign lk_set = set_of(req_vaddr);

  // Translation and row read proceed side by side off the same request.
  vipt_tlb #(
    .VPN_W(VPN_W), .PFN_W(PFN_W), .ENTRIES(TLB_ENTRIES)
  ) u_tlb (
    .clk(clk), .rst_n(rst_n), .flush(flush_all),
    .wr_en(tlb_wr), .wr_slot(tlb_wr_slot), .wr_vpn(tlb_wr_vpn), .wr_pfn(tlb_wr_pfn),
    .lk_vpn(lk_vpn), .lk_hit(tlb_hit), .lk_pfn(tlb_pfn),
    .hit_vec(tlb_hit_vec), .any_valid(tlb_valid_any)
  );

  vipt_tag_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(PFN_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_n), .flush(flush_all),
    .rd_set(lk_set), .rd_tags(row_tags), .rd_valid(row_valid),
    .fill_en(fill_valid), .fill_set(fill_set), .fill_tag(fill_pfn),
    .victim(fill_victim), .any_valid(lines_valid_any)
  );

  vipt_way_match #(
    .WAYS(WAYS), .TAG_W(PFN_W)
  ) u_match (
    .tags(row_tags), .valid(row_valid), .key(tlb_pfn),
    .hit_vec(way_hit_vec), .hit(line_hit), .hit_way(line_way)
  );

  if (COLOR_BITS > 0) begin : g_color
    assign color_bad = tlb_hit &&
                       (lk_vpn[COLOR_BITS-1:0] != tlb_pfn[COLOR_BITS-1:0]);
  end else begin : g_nocolor
    assign color_bad = 1'b0;
  end

  assign lk_kind = classify(req_valid, tlb_hit, color_bad, line_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_way       <= '0;
      rsp_paddr     <= '0;
      rsp_tlb_miss  <= 1'b0;
      rsp_color_err <= 1'b0;
    end else begin
      rsp_valid     <= (lk_kind != LK_IDLE);
      rsp_hit       <= (lk_kind == LK_HIT);
      rsp_way       <= (lk_kind == LK_HIT) ? line_way : '0;
      rsp_paddr     <= (req_valid && tlb_hit) ? join_pa(tlb_pfn, req_vaddr) : '0;
      rsp_tlb_miss  <= (lk_kind == LK_TLB_MISS);
      rsp_color_err <= (lk_kind == LK_COLOR_ERR);
    end
  end

endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk #(
  parameter int WAYS    = 8,
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush_all,
  input logic               req_valid,
  input logic               fill_valid,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_tlb_miss,
  input logic               rsp_color_err,
  input logic [ENTRIES-1:0] tlb_hit_vec,
  input logic [WAYS-1:0]    way_hit_vec,
  input logic               lines_valid_any,
  input logic               tlb_valid_any
);

  assert_rsp_follows_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_rsp_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_tlb_miss_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && tlb_hit_vec == '0) |=> (rsp_tlb_miss && !rsp_hit && !rsp_color_err));

  assert_no_way_no_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && way_hit_vec == '0) |=> !rsp_hit);

  assert_hit_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  assert_color_blocks_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_color_err |-> (!rsp_hit && !rsp_tlb_miss));

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (!lines_valid_any && !tlb_valid_any));

  assert_fill_marks_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush_all) |=> lines_valid_any);

endmodule

bind vipt_lookup vipt_lookup_chk #(.WAYS(WAYS), .ENTRIES(TLB_ENTRIES)) u_chk (.*);

// File: tb/sim_vipt_lookup.sv
`timescale 1ns/1ps
module sim_vipt_lookup;

  localparam int VA_W = 24, PA_W = 24, SETS = 128, WAYS = 2, TLBN = 4, COLOR = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_all = 1'b0;
  logic        req_valid = 1'b0;
  logic [23:0] req_vaddr = '0;
  logic        tlb_wr = 1'b0;
  logic [1:0]  tlb_wr_slot = '0;
  logic [11:0] tlb_wr_vpn = '0;
  logic [11:0] tlb_wr_pfn = '0;
  logic        fill_valid = 1'b0;
  logic [6:0]  fill_set = '0;
  logic [11:0] fill_pfn = '0;
  logic        fill_victim;
  logic        rsp_valid, rsp_hit, rsp_tlb_miss, rsp_color_err;
  logic        rsp_way;
  logic [23:0] rsp_paddr;

  always #10 clk = ~clk;

  vipt_lookup #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(12), .LINE_BITS(6), .SETS(SETS),
    .WAYS(WAYS), .TLB_ENTRIES(TLBN), .COLOR_BITS(COLOR)
  ) u0 (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  // Bench-side model.
  int m_tag [SETS][WAYS];
  bit m_v   [SETS][WAYS];
  int m_rr  [SETS];
  bit t_v   [TLBN];
  int t_vpn [TLBN];
  int t_pfn [TLBN];

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int va_of(int vpn, int set, int byte_off);
    return (vpn << 12) | ((set & 63) << 6) | (byte_off & 63);
  endfunction

  // One clock: entered and left at a falling edge.
  task automatic cycle(bit rq, int va, bit fl, int fset, int fpfn,
                       bit tw, int tslot, int tvpn, int tpfn, bit fsh, string tag);
    bit e_miss, e_cerr, e_hit; int e_way, e_pa, pfn, vpn, set, slot;
    vpn = (va >> 12) & 12'hFFF; set = (va >> 6) & 127;
    slot = -1;
    for (int i = TLBN - 1; i >= 0; i--) if (t_v[i] && t_vpn[i] == vpn) slot = i;
    e_miss = (slot < 0); pfn = e_miss ? 0 : t_pfn[slot];
    e_cerr = !e_miss && ((vpn & 1) != (pfn & 1));
    e_hit = 0; e_way = 0;
    if (!e_miss && !e_cerr)
      for (int w = WAYS - 1; w >= 0; w--)
        if (m_v[set][w] && m_tag[set][w] == pfn) begin e_hit = 1; e_way = w; end
    e_pa = e_miss ? 0 : ((pfn << 12) | (va & 12'hFFF));

    req_valid = rq; req_vaddr = 24'(va);
    fill_valid = fl; fill_set = 7'(fset); fill_pfn = 12'(fpfn);
    tlb_wr = tw; tlb_wr_slot = 2'(tslot); tlb_wr_vpn = 12'(tvpn); tlb_wr_pfn = 12'(tpfn);
    flush_all = fsh;
    #1;
    if (fl) chk("R7", "fill_victim", fill_victim, m_rr[fset]);
    // model update after expectations are taken
    if (fsh) begin
      for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) m_v[s][w] = 0;
      for (int i = 0; i < TLBN; i++) t_v[i] = 0;
    end else begin
      if (fl) begin
        m_tag[fset][m_rr[fset]] = fpfn; m_v[fset][m_rr[fset]] = 1;
        m_rr[fset] = (m_rr[fset] + 1) % WAYS;
      end
      if (tw) begin t_v[tslot] = 1; t_vpn[tslot] = tvpn; t_pfn[tslot] = tpfn; end
    end
    @(negedge clk);
    req_valid = 0; fill_valid = 0; tlb_wr = 0; flush_all = 0;
    if (rq) begin
      chk("R6", "rsp_valid", rsp_valid, 1);
      chk("R5", "rsp_tlb_miss", rsp_tlb_miss, e_miss);
      chk("R9", "rsp_color_err", rsp_color_err, e_cerr);
      chk(tag, "rsp_hit", rsp_hit, e_hit);
      chk(tag, "rsp_way", rsp_way, e_way);
      chk("R1", "rsp_paddr", rsp_paddr, e_pa);
    end else begin
      chk("R6", "rsp_valid idle", rsp_valid, 0);
    end
  endtask

  task automatic lookup(int va, string tag);
    cycle(1, va, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic fill(int set, int pfn);
    cycle(0, 0, 1, set, pfn, 0, 0, 0, 0, 0, "R7");
  endtask
  task automatic twrite(int slot, int vpn, int pfn);
    cycle(0, 0, 0, 0, 0, 1, slot, vpn, pfn, 0, "R10");
  endtask

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin m_v[s][w] = 0; m_tag[s][w] = 0; end
    end
    for (int i = 0; i < TLBN; i++) begin t_v[i] = 0; t_vpn[i] = 0; t_pfn[i] = 0; end

    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "rsp_valid", rsp_valid, 0);
    chk("R11", "rsp_hit", rsp_hit, 0);
    fill_set = 7'd0;   #1 chk("R11", "fill_victim set0", fill_victim, 0);
    fill_set = 7'd127; #1 chk("R11", "fill_victim set127", fill_victim, 0);
    rst_n = 1;
    @(negedge clk);

    lookup(va_of(12'h010, 1, 0), "R5");            // empty translation buffer
    lookup(va_of(12'h010, 1, 0), "R11");           // no valid lines either

    twrite(0, 12'h010, 12'h230);
    twrite(1, 12'h022, 12'h230);                   // alias of slot 0
    twrite(2, 12'h031, 12'h101);
    twrite(3, 12'h045, 12'h0A2);                   // colour mismatch
    lookup(va_of(12'h010, 1, 4), "R3");            // translation hit, line miss

    // Sweep the lower half (colour bit 0) through both aliases.
    for (int s = 0; s < 64; s++) begin
      fill(s, 12'h230);
      lookup(va_of(12'h010, s, s * 5), "R3");
      lookup(va_of(12'h022, s, 63 - s), "R4");
    end
    // Upper half (colour bit 1).
    for (int s = 64; s < 128; s++) begin
      fill(s, 12'h101);
      lookup(va_of(12'h031, s, s), "R3");
    end

    // Round-robin within set 5, then wrap and evict.
    fill(5, 12'h3F0);
    lookup(va_of(12'h010, 5, 0), "R7");            // still way 0
    fill(5, 12'h2F2);
    lookup(va_of(12'h010, 5, 0), "R7");            // evicted
    lookup(va_of(12'h010, 6, 9), "R2");            // neighbour untouched
    lookup(va_of(12'h022, 4, 33), "R2");

    for (int s = 0; s < 4; s++) lookup(va_of(12'h045, s, s), "R9");

    twrite(3, 12'h045, 12'h101);                   // replace slot 3
    lookup(va_of(12'h045, 3, 0), "R10");           // set 67, hit way 0
    twrite(3, 12'h010, 12'h3F0);                   // duplicate VPN, higher slot
    lookup(va_of(12'h010, 5, 0), "R10");           // slot 0 wins: miss

    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R8");     // flush
    lookup(va_of(12'h010, 6, 0), "R8");
    twrite(0, 12'h010, 12'h230);
    lookup(va_of(12'h010, 6, 0), "R8");            // lines gone
    cycle(0, 0, 1, 9, 12'h230, 1, 1, 12'h022, 12'h230, 1, "R8");
    lookup(va_of(12'h022, 9, 0), "R8");            // dropped translation write
    lookup(va_of(12'h010, 9, 0), "R8");            // dropped refill

    // Same-cycle request and refill of set 7 (pointer kept at way 1).
    cycle(1, va_of(12'h010, 7, 2), 1, 7, 12'h230, 0, 0, 0, 0, 0, "R6");
    lookup(va_of(12'h010, 7, 2), "R6");
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule